// File: doc/BRIEF.md
# Serial Sampling Converter Read Controller

This block sits on the host side of a 12-bit serial sampling converter. On a start request it pulses the conversion-start line low, holds chip select active, and supplies exactly twelve data clock cycles to shift the result out, MSB first. The data clock is derived from the system clock by an even, programmable ratio. The assembled word is presented with a single-cycle valid strobe.

Two read policies are chosen per request by a mode input. In the quiet policy, the data clock stays low for the whole conversion and the twelve clocks run after the converter drops its busy flag. In the overlapped policy, the twelve clocks run while the new conversion is still busy. They read the word the converter kept from the previous conversion, and the controller waits for busy to clear before it reports. In both policies the data clock is parked low whenever no bits are being moved. This keeps it static around sampling and lets the converter load each new result.

Top module: `adc_serial_reader`

## Requirements
- R1: After reset and whenever no read is in progress, cs_n_o is 1, sclk_o is 0, conv_n_o is 1 and valid_o is 0.
- R2: When start_i is sampled high in idle, conv_n_o goes low for exactly CONV_W system cycles, once. Further start requests are ignored until valid_o has been issued.
- R3: With mode_i = 0, sclk_o makes no rising edge while busy_i is high. The twelve clocks follow the falling edge of busy_i.
- R4: With mode_i = 1, all twelve sclk_o rising edges occur while busy_i is high. valid_o is only raised after busy_i has returned low.
- R5: Each read issues exactly NBITS (12) rising edges on sclk_o, and sclk_o stays low afterwards, so no thirteenth clock is issued.
- R6: sclk_o is high for H system cycles and low for H system cycles, where H = div_half_i. A value of 0 is treated as 1, so the period is 2*H.
- R7: sdata_i is sampled on each falling edge of sclk_o. The first sampled bit lands in word_o[NBITS-1] and the last one in word_o[0].
- R8: valid_o is high for exactly one cycle per read. word_o changes only in a cycle in which valid_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one conversion and read |
| mode_i | input | 1 | 0: read after conversion, 1: read during the next conversion |
| div_half_i | input | DIV_W | Data clock half period in system cycles (0 acts as 1) |
| busy_i | input | 1 | Converter busy flag, high while converting |
| sdata_i | input | 1 | Converter serial data, launched on sclk rising edge |
| conv_n_o | output | 1 | Conversion start, active low |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Data clock to the converter |
| valid_o | output | 1 | One-cycle result strobe |
| word_o | output | NBITS | Assembled result word |

## Verification
The assertions check on every cycle that the data clock is low while chip select is inactive, and that it is low throughout a busy period under the quiet policy. They also check that the bit counter never passes twelve, that the valid strobe lasts one cycle and is only raised with busy low, that the word moves only with the strobe, and that a conversion pulse starts only from idle. Some properties need a converter model and can only be shown by the bench scenarios. These are the bit order and values of the returned word, the exact clock count and period for each divider setting, and the single conversion pulse under a held start request. Another is the overlapped read returning the previous word, or all zeros when that word was already read out.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PULSE,
    S_ARM,
    S_WAITEND,
    S_SHIFT,
    S_DRAIN,
    S_DONE
  } rd_state_e;

  // Effective half period: a zero setting behaves as one.
  function automatic int unsigned eff_half(input int unsigned half);
    return (half == 0) ? 1 : half;
  endfunction

  // True on the last system cycle of a data clock phase.
  function automatic logic phase_end(input int unsigned cnt, input int unsigned half);
    return cnt >= (eff_half(half) - 1);
  endfunction

endpackage

// File: rtl/adc_rd_clkgen.sv
module adc_rd_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             sclk_o,
  output logic             fall_o
);
  import adc_rd_pkg::*;

  logic [DIV_W-1:0] cnt_q;
  logic             sclk_q;
  logic             term;

  assign term = phase_end(32'(cnt_q), 32'(half_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (term) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign sclk_o = sclk_q;
  // Edge at which the data clock goes from high to low.
  assign fall_o = en_i & term & sclk_q;

endmodule

// File: rtl/adc_rd_shifter.sv
module adc_rd_shifter #(
  parameter int NBITS = 12,
  localparam int CNT_W = $clog2(NBITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             fall_i,
  input  logic             sdata_i,
  output logic [NBITS-1:0] word_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);
  logic [NBITS-1:0] sreg_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      cnt_q  <= '0;
    end else if (fall_i && !done_o) begin
      sreg_q <= {sreg_q[NBITS-2:0], sdata_i};
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign word_o = sreg_q;
  assign cnt_o  = cnt_q;
  assign done_o = (cnt_q == CNT_W'(NBITS));

endmodule

// File: rtl/adc_rd_fsm.sv
module adc_rd_fsm #(
  parameter int CONV_W = 4,
  localparam int PW = $clog2(CONV_W + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  mode_i,
  input  logic                  busy_i,
  input  logic                  shift_done_i,
  output adc_rd_pkg::rd_state_e state_o,
  output logic                  mode_q_o
);
  import adc_rd_pkg::*;

  rd_state_e   state_q;
  logic        mode_q;
  logic [PW-1:0] pcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      mode_q  <= 1'b0;
      pcnt_q  <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          state_q <= S_PULSE;
          mode_q  <= mode_i;
          pcnt_q  <= '0;
        end
        S_PULSE: begin
          if (pcnt_q == PW'(CONV_W - 1)) state_q <= S_ARM;
          else pcnt_q <= pcnt_q + 1'b1;
        end
        S_ARM:     if (busy_i) state_q <= mode_q ? S_SHIFT : S_WAITEND;
        S_WAITEND: if (!busy_i) state_q <= S_SHIFT;
        S_SHIFT:   if (shift_done_i) state_q <= mode_q ? S_DRAIN : S_DONE;
        S_DRAIN:   if (!busy_i) state_q <= S_DONE;
        S_DONE:    state_q <= S_IDLE;
        default:   state_q <= S_IDLE;
      endcase
    end
  end

  assign state_o  = state_q;
  assign mode_q_o = mode_q;

endmodule

// File: rtl/adc_serial_reader.sv
module adc_serial_reader #(
  parameter int NBITS  = 12,
  parameter int DIV_W  = 8,
  parameter int CONV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             mode_i,
  input  logic [DIV_W-1:0] div_half_i,
  input  logic             busy_i,
  input  logic             sdata_i,
  output logic             conv_n_o,
  output logic             cs_n_o,
  output logic             sclk_o,
  output logic             valid_o,
  output logic [NBITS-1:0] word_o
);
  import adc_rd_pkg::*;

  localparam int CNT_W = $clog2(NBITS + 1);

  rd_state_e        state;
  logic             mode_q_w;
  logic             idle_w;
  logic             shift_done;
  logic             sclk_en;
  logic             fall_evt;
  logic [CNT_W-1:0] bit_cnt_w;
  logic [NBITS-1:0] shreg;
  logic [NBITS-1:0] word_q;

  adc_rd_fsm #(.CONV_W(CONV_W)) fsm_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .busy_i(busy_i), .shift_done_i(shift_done),
    .state_o(state), .mode_q_o(mode_q_w)
  );

  assign idle_w  = (state == S_IDLE);
  assign sclk_en = (state == S_SHIFT) && !shift_done;

  adc_rd_clkgen #(.DIV_W(DIV_W)) clkgen_i (
    .clk(clk), .rst_n(rst_n), .en_i(sclk_en), .half_i(div_half_i),
    .sclk_o(sclk_o), .fall_o(fall_evt)
  );

  adc_rd_shifter #(.NBITS(NBITS)) shifter_i (
    .clk(clk), .rst_n(rst_n), .clr_i(idle_w), .fall_i(fall_evt),
    .sdata_i(sdata_i), .word_o(shreg), .cnt_o(bit_cnt_w), .done_o(shift_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else if (state == S_SHIFT && shift_done && !mode_q_w) word_q <= shreg;
    else if (state == S_DRAIN && !busy_i) word_q <= shreg;
  end

  assign conv_n_o = (state != S_PULSE);
  assign cs_n_o   = idle_w;
  assign valid_o  = (state == S_DONE);
  assign word_o   = word_q;

endmodule

// File: rtl/adc_serial_reader_chk.sv
module adc_serial_reader_chk #(
  parameter int NBITS = 12,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n_o,
  input logic             sclk_o,
  input logic             conv_n_o,
  input logic             busy_i,
  input logic             valid_o,
  input logic [NBITS-1:0] word_o,
  input logic             idle_w,
  input logic             mode_q_w,
  input logic [CNT_W-1:0] bit_cnt_w
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sclk_o);

  p_start_from_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_n_o) |-> $past(idle_w));

  p_quiet_conv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q_w && busy_i && !cs_n_o) |-> !sclk_o);

  p_report_after_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> !busy_i);

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt_w <= CNT_W'(NBITS));

  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  p_word_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word_o) |-> valid_o);

endmodule

bind adc_serial_reader adc_serial_reader_chk #(.NBITS(NBITS), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
  .conv_n_o(conv_n_o), .busy_i(busy_i), .valid_o(valid_o), .word_o(word_o),
  .idle_w(idle_w), .mode_q_w(mode_q_w), .bit_cnt_w(bit_cnt_w)
);

// File: tb/adc_serial_reader_tb_top.sv
`timescale 1ns/1ps
module adc_serial_reader_tb_top;
  localparam int NBITS    = 12;
  localparam int DIV_W    = 8;
  localparam int CONV_W   = 4;
  localparam int CONV_CYC = 120;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic mode_i = 1'b0;
  logic [DIV_W-1:0] div_half_i = 8'd1;
  logic busy_i = 1'b0;
  logic sdata_i = 1'b0;
  logic conv_n_o, cs_n_o, sclk_o, valid_o;
  logic [NBITS-1:0] word_o;

  always #10 clk = ~clk;

  adc_serial_reader #(.NBITS(NBITS), .DIV_W(DIV_W), .CONV_W(CONV_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .div_half_i(div_half_i), .busy_i(busy_i), .sdata_i(sdata_i),
    .conv_n_o(conv_n_o), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
    .valid_o(valid_o), .word_o(word_o)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int cyc = 0;

  // converter model state
  logic [NBITS-1:0] conv_reg = '0;
  logic [NBITS-1:0] next_word = '0;
  logic [NBITS-1:0] exp_prev = '0;
  int k = 0;
  int pend = 0;
  int busy_left = 0;
  logic prev_conv = 1'b1, prev_sclk = 1'b0;
  // per-transaction observations
  int rises = 0, rises_busy = 0, conv_falls = 0, conv_low = 0, valid_cnt = 0;
  int rise_t0 = -1, rise_t1 = -1;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int half_eff(input int h);
    return (h == 0) ? 1 : h;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Converter model, evaluated away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (!conv_n_o) conv_low++;
      if (valid_o) valid_cnt++;
      if (prev_conv && !conv_n_o) begin
        conv_falls++;
        if (!busy_i && pend == 0) pend = 3;
      end else if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          busy_i = 1'b1;
          busy_left = CONV_CYC;
          exp_prev = (k == 0) ? conv_reg : '0;
        end
      end else if (busy_i) begin
        busy_left--;
        if (busy_left == 0) begin
          busy_i = 1'b0;
          if (!sclk_o || cs_n_o) begin
            conv_reg = next_word;
            k = 0;
            sdata_i = 1'b0;
          end
        end
      end
      if (!prev_sclk && sclk_o) begin
        rises++;
        if (busy_i) rises_busy++;
        if (rise_t0 < 0) rise_t0 = cyc; else if (rise_t1 < 0) rise_t1 = cyc;
        sdata_i = (k < NBITS) ? conv_reg[NBITS-1-k] : 1'b0;
        if (k < NBITS + 1) k++;
      end
      prev_conv = conv_n_o;
      prev_sclk = sclk_o;
    end
  end

  task automatic do_read(input bit m, input int h, input logic [NBITS-1:0] w);
    logic [NBITS-1:0] expw;
    @(negedge clk);
    rises = 0; rises_busy = 0; conv_falls = 0; conv_low = 0; valid_cnt = 0;
    rise_t0 = -1; rise_t1 = -1;
    next_word = w;
    mode_i = m;
    div_half_i = DIV_W'(h);
    start_i = 1'b1;   // held high through the read: extra requests must be ignored
    while (!valid_o) @(negedge clk);
    expw = m ? exp_prev : w;
    chk(word_o == expw, m ? "R4/R7 overlapped word" : "R3/R7 quiet word", word_o, expw);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(rises == NBITS, "R5 clock count", rises, NBITS);
    chk(sclk_o == 1'b0 && cs_n_o == 1'b1, "R5 R1 parked after read", sclk_o, 0);
    chk(conv_falls == 1, "R2 single conversion pulse", conv_falls, 1);
    chk(conv_low == CONV_W, "R2 pulse width", conv_low, CONV_W);
    chk(valid_cnt == 1, "R8 valid width", valid_cnt, 1);
    chk(rise_t1 - rise_t0 == 2 * half_eff(h), "R6 clock period", rise_t1 - rise_t0, 2 * half_eff(h));
    if (m) chk(rises_busy == NBITS, "R4 clocks inside busy", rises_busy, NBITS);
    else   chk(rises_busy == 0, "R3 no clocks inside busy", rises_busy, 0);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(cs_n_o && !sclk_o && conv_n_o && !valid_o, "R1 reset state",
        {cs_n_o, sclk_o, conv_n_o, valid_o}, 4'b1010);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cs_n_o && !sclk_o && conv_n_o && !valid_o, "R1 idle state",
        {cs_n_o, sclk_o, conv_n_o, valid_o}, 4'b1010);
    // directed corners
    do_read(1'b1, 1, 12'hABC);   // nothing loaded before: previous word is 0
    do_read(1'b1, 2, 12'h123);   // returns 12'hABC, unread from the last read
    do_read(1'b0, 0, 12'hFFF);   // half period 0 acts as 1
    do_read(1'b1, 1, 12'h555);   // previous word already read: 13th-clock zeros
    do_read(1'b0, 3, 12'h800);   // MSB only
    do_read(1'b0, 1, 12'h001);   // LSB only
    do_read(1'b0, 4, 12'hA5A);
    // random mix
    for (int i = 0; i < 20; i++) begin
      do_read(1'($urandom_range(0, 1)), int'($urandom_range(0, 4)),
              NBITS'($urandom));
    end
    if (!finished) begin
      finished = 1;
      summary();
      $finish;
    end
  end

endmodule